// File: doc/BRIEF.md
# Paged memory expansion mapper

This block translates host accesses in a 32K memory expansion area into addresses of a 1 MB paged RAM. The host bus has 16 address bits and 8 data bits. The 64K host space is treated as sixteen 4K windows. Eight of these windows are mapped: 0x2000 and 0x3000 in the low 8K, and 0xA000 through 0xF000 in the high 24K. A host access to a mapped window selects the RAM. The RAM address is built from an 8-bit page number and the low 12 host address bits.

A two-bit control port sits at a fixed base of 0x1E00. It takes single-bit writes.
- Bit 0 opens a register window in the 8K region at 0x4000–0x5FFF. Through that window the host reads and writes one page register for each window.
- Bit 1 switches from pass mode to map mode. In pass mode each window lands on the page equal to its own 4K index. In map mode each window uses its page register.

After reset the block behaves as a plain 32K expansion. The block also drives a gated memory enable onto a pass-through connector. That enable is held inactive while the host touches a mapped window, so cards further down the bus ignore those accesses.

Top module: `paged_mapper`

## Requirements
- R1: After reset both control bits are 0. A host read in 0x4000–0x5FFF leaves data_oe_o low, and the block is in pass mode.
- R2: ram_cs_no is low exactly when mem_en_ni is low and addr_i[15:12] is one of 2, 3, 0xA, 0xB, 0xC, 0xD, 0xE or 0xF.
- R3: In pass mode (control bit 1 clear), ram_addr_o equals {4'h0, addr_i[15:12], addr_i[11:0]}.
- R4: In map mode (control bit 1 set), ram_addr_o equals {page register of window addr_i[15:12], addr_i[11:0]} for mapped windows.
- R5: pass_mem_en_no is 1 whenever ram_cs_no is low. For every other address, including 0x4000–0x5FFF, it equals mem_en_ni.
- R6: A cycle with ctl_wr_i high and ctl_addr_i = 0x1E00 + 2k loads ctl_bit_i into control bit k (k = 0 is register-window enable, k = 1 is map mode). The new value is visible from the next cycle. Odd addresses and addresses outside the two bits are ignored.
- R7: While control bit 0 is set, a host write (mem_en_ni and we_ni low) anywhere in 0x4000–0x5FFF loads data_i into the page register of window n = addr_i[4:1]. The two byte offsets 2n and 2n+1 reach the same register, and the pattern repeats every 32 bytes.
- R8: While control bit 0 is set, a host read in 0x4000–0x5FFF raises data_oe_o. data_o then carries the page register of window addr_i[4:1], or 0 for an unmapped window. With no such read, data_oe_o is low.
- R9: Page-register writes to unmapped windows are ignored, and so are writes made while control bit 0 is clear.
- R10: On reset, each mapped window's page register holds its own 4K index.
- R11: A page-register write and a control write that clears bit 0, made in the same cycle, still load the page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Host address |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Page register read data |
| data_oe_o | output | 1 | Read data drive enable |
| mem_en_ni | input | 1 | Host memory enable, active low |
| we_ni | input | 1 | Host write strobe, active low |
| ctl_wr_i | input | 1 | Control port bit write strobe |
| ctl_addr_i | input | 16 | Control port bit address |
| ctl_bit_i | input | 1 | Control port bit value |
| ram_cs_no | output | 1 | RAM chip select, active low |
| ram_addr_o | output | 20 | Extended RAM address |
| pass_mem_en_no | output | 1 | Gated memory enable to pass-through connector |

## Verification
A page-register write through the host bus and a control-port write can land on the same clock edge. The critical case is a control write that closes the register window in the very cycle the host writes a page. The bench drives both strobes on one negative edge, writing window 0xA while clearing control bit 0. It then reopens the window, reads the register back, and expects the new byte, because the enable in force during that edge was the old one. The same sweep also confirms that the window is closed right afterwards: a read in that state leaves data_oe_o low.

// File: rtl/paged_mapper_pkg.sv
package paged_mapper_pkg;
  localparam int CTL_N      = 2;
  localparam int CTL_REG_EN = 0;
  localparam int CTL_MAP    = 1;
endpackage

// File: rtl/pm_ctl_bits.sv
module pm_ctl_bits #(
  parameter int          ADDR_W   = 16,
  parameter int          CTL_N    = 2,
  parameter logic [15:0] CTL_BASE = 16'h1E00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bit_i,
  output logic [CTL_N-1:0]  ctl_o
);
  for (genvar k = 0; k < CTL_N; k++) begin : g_bit
    localparam logic [ADDR_W-1:0] BIT_ADDR = ADDR_W'(CTL_BASE) + ADDR_W'(2 * k);
    logic hit;
    assign hit = wr_i && (addr_i == BIT_ADDR);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ctl_o[k] <= 1'b0;
      else if (hit) ctl_o[k] <= bit_i;
    end
  end
endmodule

// File: rtl/pm_decode.sv
module pm_decode #(
  parameter int          ADDR_W   = 16,
  parameter int          WIN_W    = 12,
  parameter int          NWIN     = 16,
  parameter logic [15:0] MAP_MASK = 16'hFC0C,
  parameter logic [15:0] REG_BASE = 16'h4000,
  parameter int          REG_AW   = 13,
  localparam int         SEL_W    = $clog2(NWIN)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mem_en_ni,
  output logic [SEL_W-1:0]  win_o,
  output logic              win_hit_o,
  output logic              reg_hit_o,
  output logic [SEL_W-1:0]  reg_sel_o
);
  localparam logic [ADDR_W-REG_AW-1:0] REG_TAG = REG_BASE[ADDR_W-1:REG_AW];

  assign win_o     = addr_i[ADDR_W-1:WIN_W];
  assign win_hit_o = !mem_en_ni && MAP_MASK[win_o];
  assign reg_hit_o = !mem_en_ni && (addr_i[ADDR_W-1:REG_AW] == REG_TAG);
  // two byte offsets per register
  assign reg_sel_o = addr_i[SEL_W:1];
endmodule

// File: rtl/pm_page_file.sv
module pm_page_file #(
  parameter int          NWIN     = 16,
  parameter int          PAGE_W   = 8,
  parameter logic [15:0] MAP_MASK = 16'hFC0C,
  localparam int         SEL_W    = $clog2(NWIN)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [SEL_W-1:0]       wr_sel_i,
  input  logic [PAGE_W-1:0]      wr_data_i,
  input  logic [SEL_W-1:0]       rd_sel_i,
  output logic [PAGE_W-1:0]      rd_data_o,
  output logic [NWIN*PAGE_W-1:0] pages_o
);
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    if (MAP_MASK[i]) begin : g_reg
      logic [PAGE_W-1:0] page_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             page_q <= PAGE_W'(i);
        else if (wr_i && wr_sel_i == SEL_W'(i))  page_q <= wr_data_i;
      end
      assign pages_o[i*PAGE_W +: PAGE_W] = page_q;
    end else begin : g_none
      assign pages_o[i*PAGE_W +: PAGE_W] = '0;
    end
  end

  assign rd_data_o = pages_o[rd_sel_i*PAGE_W +: PAGE_W];
endmodule

// File: rtl/paged_mapper.sv
module paged_mapper
  import paged_mapper_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          PAGE_W   = 8,
  parameter int          WIN_W    = 12,
  parameter logic [15:0] MAP_MASK = 16'hFC0C,
  parameter logic [15:0] CTL_BASE = 16'h1E00,
  parameter logic [15:0] REG_BASE = 16'h4000,
  parameter int          REG_AW   = 13,
  localparam int         NWIN     = 2 ** (ADDR_W - WIN_W),
  localparam int         SEL_W    = $clog2(NWIN),
  localparam int         RAM_AW   = PAGE_W + WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W-1:0] data_i,
  output logic [PAGE_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              mem_en_ni,
  input  logic              we_ni,
  input  logic              ctl_wr_i,
  input  logic [ADDR_W-1:0] ctl_addr_i,
  input  logic              ctl_bit_i,
  output logic              ram_cs_no,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              pass_mem_en_no
);
  logic [CTL_N-1:0]       ctl_q;
  logic [SEL_W-1:0]       win, reg_sel;
  logic                   win_hit, reg_hit, reg_en, map_en, page_wr;
  logic [PAGE_W-1:0]      rd_page;
  logic [NWIN*PAGE_W-1:0] page_flat;
  logic [PAGE_W-1:0]      cur_page;

  pm_ctl_bits #(.ADDR_W(ADDR_W), .CTL_N(CTL_N), .CTL_BASE(CTL_BASE)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(ctl_wr_i), .addr_i(ctl_addr_i),
    .bit_i(ctl_bit_i), .ctl_o(ctl_q));

  pm_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .NWIN(NWIN), .MAP_MASK(MAP_MASK),
              .REG_BASE(REG_BASE), .REG_AW(REG_AW)) u_dec (
    .addr_i(addr_i), .mem_en_ni(mem_en_ni), .win_o(win), .win_hit_o(win_hit),
    .reg_hit_o(reg_hit), .reg_sel_o(reg_sel));

  assign reg_en  = ctl_q[CTL_REG_EN];
  assign map_en  = ctl_q[CTL_MAP];
  assign page_wr = reg_hit && reg_en && !we_ni;

  pm_page_file #(.NWIN(NWIN), .PAGE_W(PAGE_W), .MAP_MASK(MAP_MASK)) u_pages (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(page_wr), .wr_sel_i(reg_sel),
    .wr_data_i(data_i), .rd_sel_i(reg_sel), .rd_data_o(rd_page),
    .pages_o(page_flat));

  assign data_oe_o = reg_hit && reg_en && we_ni;
  assign data_o    = data_oe_o ? rd_page : '0;

  assign cur_page       = map_en ? page_flat[win*PAGE_W +: PAGE_W] : PAGE_W'(win);
  assign ram_cs_no      = !win_hit;
  assign ram_addr_o     = {cur_page, addr_i[WIN_W-1:0]};
  assign pass_mem_en_no = mem_en_ni || win_hit;
endmodule

// File: rtl/paged_mapper_chk.sv
module paged_mapper_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int WIN_W  = 12,
  parameter int NWIN   = 16,
  parameter int CTL_N  = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   mem_en_ni,
  input logic                   we_ni,
  input logic                   ctl_wr_i,
  input logic                   data_oe_o,
  input logic                   ram_cs_no,
  input logic [PAGE_W+WIN_W-1:0] ram_addr_o,
  input logic                   pass_mem_en_no,
  input logic [CTL_N-1:0]       ctl_q,
  input logic [NWIN*PAGE_W-1:0] pages
);
  // R5: downstream never sees a mapped access
  p_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_cs_no |-> pass_mem_en_no);
  // R2: chip select only with host enable
  p_cs_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_ni |-> ram_cs_no);
  // R3 and R4: offset bits carried through
  p_offset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_cs_no |-> ram_addr_o[WIN_W-1:0] == addr_i[WIN_W-1:0]);
  p_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_cs_no && !ctl_q[1]) |-> ram_addr_o[PAGE_W+WIN_W-1:WIN_W] == PAGE_W'(addr_i[ADDR_W-1:WIN_W]));
  // R6: control bits move only on a control write
  p_ctl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr_i |=> $stable(ctl_q));
  // R8: read drive only inside an enabled host read
  p_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (ctl_q[0] && we_ni && !mem_en_ni));
  // R9: page registers hold without an enabled write
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_ni || we_ni || !ctl_q[0]) |=> $stable(pages));
endmodule

bind paged_mapper paged_mapper_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W), .NWIN(NWIN), .CTL_N(paged_mapper_pkg::CTL_N)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .mem_en_ni(mem_en_ni),
  .we_ni(we_ni), .ctl_wr_i(ctl_wr_i), .data_oe_o(data_oe_o), .ram_cs_no(ram_cs_no),
  .ram_addr_o(ram_addr_o), .pass_mem_en_no(pass_mem_en_no), .ctl_q(ctl_q),
  .pages(page_flat));

// File: tb/paged_mapper_bench.sv
module paged_mapper_bench;
  logic        clk_i = 0, rst_ni = 0;
  logic [15:0] addr_i = '0, ctl_addr_i = '0;
  logic [7:0]  data_i = '0, data_o;
  logic        data_oe_o, mem_en_ni = 1, we_ni = 1, ctl_wr_i = 0, ctl_bit_i = 0;
  logic        ram_cs_no, pass_mem_en_no;
  logic [19:0] ram_addr_o;
  int checks = 0, errors = 0;
  logic [7:0] exp_pg [16];
  localparam logic [15:0] MASK = 16'hFC0C;

  always #2 clk_i = ~clk_i;

  paged_mapper u_paged_mapper (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic host_read(input logic [15:0] a);
    @(negedge clk_i); addr_i = a; mem_en_ni = 0; we_ni = 1; #1;
  endtask

  task automatic host_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; data_i = d; mem_en_ni = 0; we_ni = 0;
    @(negedge clk_i); mem_en_ni = 1; we_ni = 1;
  endtask

  task automatic ctl_write(input logic [15:0] a, input logic b);
    @(negedge clk_i); ctl_addr_i = a; ctl_bit_i = b; ctl_wr_i = 1;
    @(negedge clk_i); ctl_wr_i = 0;
  endtask

  task automatic sweep_windows(input bit map_mode, input string req);
    for (int w = 0; w < 16; w++) begin
      for (int o = 0; o < 3; o++) begin
        logic [15:0] a;
        logic [11:0] off;
        bit mapped;
        off = (o == 0) ? 12'h000 : (o == 1) ? 12'h7FF : 12'hFFF;
        a = {w[3:0], off};
        mapped = MASK[w];
        @(negedge clk_i); addr_i = a; mem_en_ni = 1; we_ni = 1; #1;
        chk(ram_cs_no == 1'b1, "R2 idle cs", ram_cs_no, 1);
        chk(pass_mem_en_no == 1'b1, "R5 idle pass", pass_mem_en_no, 1);
        host_read(a);
        chk(ram_cs_no == !mapped, "R2 cs decode", ram_cs_no, !mapped);
        chk(pass_mem_en_no == mapped, "R5 pass mask", pass_mem_en_no, mapped);
        if (mapped) begin
          logic [19:0] e;
          e = map_mode ? {exp_pg[w], off} : {4'h0, w[3:0], off};
          chk(ram_addr_o == e, req, ram_addr_o, e);
        end
      end
    end
    @(negedge clk_i); mem_en_ni = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_pg[i] = MASK[i] ? 8'(i) : 8'h00;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;

    // R1: register window hidden after reset
    host_read(16'h4004);
    chk(data_oe_o == 0, "R1 oe after reset", data_oe_o, 0);
    chk(pass_mem_en_no == 0, "R5 dsr not masked", pass_mem_en_no, 0);
    host_read(16'h5FFE);
    chk(pass_mem_en_no == 0, "R5 dsr top not masked", pass_mem_en_no, 0);
    sweep_windows(0, "R3 pass address");

    // R9: write while hidden is dropped
    host_write(16'h4004, 8'h55);
    // R6: ignored control addresses
    ctl_write(16'h1E04, 1);
    ctl_write(16'h1E01, 1);
    host_read(16'h4004);
    chk(data_oe_o == 0, "R6 ignored ctl addr", data_oe_o, 0);
    ctl_write(16'h1E00, 1);
    host_read(16'h4004);
    chk(data_oe_o == 1, "R6 reg enable", data_oe_o, 1);
    chk(data_o == 8'h02, "R9 R10 hidden write dropped", data_o, 2);
    for (int n = 0; n < 16; n++) begin
      host_read(16'h4000 + 16'(2 * n));
      chk(data_o == exp_pg[n], "R10 reset page", data_o, exp_pg[n]);
    end

    // R7 R8 R9: write all sixteen, read back through both offsets and a mirror
    for (int n = 0; n < 16; n++) begin
      logic [7:0] v;
      v = 8'(n * 17 + 3);
      host_write(16'h4000 + 16'(2 * n + (n & 1)), v);
      if (MASK[n]) exp_pg[n] = v;
    end
    for (int n = 0; n < 16; n++) begin
      host_read(16'h4000 + 16'(2 * n + ((n + 1) & 1)));
      chk(data_o == exp_pg[n], "R7 R8 R9 readback", data_o, exp_pg[n]);
      host_read(16'h5FE0 + 16'(2 * n));
      chk(data_o == exp_pg[n], "R7 mirror readback", data_o, exp_pg[n]);
    end
    @(negedge clk_i); mem_en_ni = 1; #1;
    chk(data_oe_o == 0, "R8 no read no oe", data_oe_o, 0);

    // R4: map mode
    ctl_write(16'h1E02, 1);
    sweep_windows(1, "R4 map address");

    // R11: page write and window close in one cycle
    @(negedge clk_i);
    addr_i = 16'h4014; data_i = 8'hC3; mem_en_ni = 0; we_ni = 0;
    ctl_addr_i = 16'h1E00; ctl_bit_i = 0; ctl_wr_i = 1;
    @(negedge clk_i); mem_en_ni = 1; we_ni = 1; ctl_wr_i = 0;
    exp_pg[10] = 8'hC3;
    host_read(16'h4014);
    chk(data_oe_o == 0, "R6 window closed", data_oe_o, 0);
    host_write(16'h4016, 8'h11);  // R9 dropped
    ctl_write(16'h1E00, 1);
    host_read(16'h4014);
    chk(data_o == 8'hC3, "R11 same-cycle write", data_o, 8'hC3);
    host_read(16'h4016);
    chk(data_o == exp_pg[11], "R9 closed write dropped", data_o, exp_pg[11]);
    host_read(16'hA123);
    chk(ram_addr_o == {8'hC3, 12'h123}, "R4 new page used", ram_addr_o, {8'hC3, 12'h123});

    // R3 again after leaving map mode
    ctl_write(16'h1E02, 0);
    host_read(16'hA123);
    chk(ram_addr_o == 20'h0A123, "R3 back to pass", ram_addr_o, 20'h0A123);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule